// File: doc/BRIEF.md
# Partial-Width Access Register File

This block holds eight 32-bit general-purpose registers behind one write port and two read ports. Each port carries a register index and a two-bit access-size selector. One storage word can then be seen as a full word, as its low half, or as either byte of that low half. Registers 0 to 3 are data registers and allow every view. Registers 4 to 7 are index and pointer registers and allow only the full-word and half-word views.

A narrow write merges into the stored word and leaves every bit outside the selected field as it was. A narrow read returns its field zero-extended. Reads are combinational from the stored state, and a write lands on the rising clock edge. If a byte view of an index or pointer register is requested on any port, the write is dropped, the read returns zero, and the error output pulses in the following cycle.

Top module: `prf_regfile`

## Requirements
- R1: An active-high synchronous reset clears all eight registers to zero and clears `acc_err`. A write presented during reset is discarded.
- R2: With selector 2'b00, a write replaces all 32 bits of the indexed register, and a read returns all 32 bits. This works for every index 0 to 7.
- R3: With selector 2'b01, a write replaces bits 15:0 of any register with `wr_data[15:0]` and keeps bits 31:16.
- R4: On registers 0 to 3, selector 2'b10 writes `wr_data[7:0]` into bits 7:0 and selector 2'b11 writes `wr_data[7:0]` into bits 15:8. All other bits are kept.
- R5: A read with selector 2'b01 returns bits 15:0, 2'b10 returns bits 7:0 and 2'b11 returns bits 15:8. In each case the field is zero-extended to 32 bits.
- R6: A write with selector 2'b10 or 2'b11 to registers 4 to 7 leaves that register unchanged.
- R7: A read with selector 2'b10 or 2'b11 of registers 4 to 7 returns zero.
- R8: `acc_err` is high in the cycle after a cycle in which an illegal byte access was presented: a write with `wr_en` high, or either read port. It is low in all other cycles.
- R9: A write is seen on the read ports from the cycle after its clock edge. In the write cycle itself the read ports show the old value. The two read ports select independently.
- R10: With `wr_en` low, no register changes, whatever the other write inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_idx | input | 3 | Write register index |
| wr_sel | input | 2 | Write access size: 00 word, 01 half, 10 low byte, 11 high byte |
| wr_data | input | 32 | Write data, field taken from the low bits |
| rd0_idx | input | 3 | Read port 0 register index |
| rd0_sel | input | 2 | Read port 0 access size |
| rd0_data | output | 32 | Read port 0 data, zero-extended |
| rd1_idx | input | 3 | Read port 1 register index |
| rd1_sel | input | 2 | Read port 1 access size |
| rd1_data | output | 32 | Read port 1 data, zero-extended |
| acc_err | output | 1 | One-cycle pulse after an illegal byte access |

## Verification
The bench builds the block with its defaults: a 32-bit word, eight registers, and the first four of them byte-addressable. With these values every index and every selector code can be reached, including the boundary between register 3, which allows byte views, and register 4, which does not. Merges into a word that already holds a known non-zero value show which bits each view keeps. Illegal requests placed next to legal ones show that the error pulse lasts a single cycle.

// File: rtl/prf_pkg.sv
package prf_pkg;
  typedef enum logic [1:0] {
    ACC_WORD = 2'b00,
    ACC_HALF = 2'b01,
    ACC_LOB  = 2'b10,
    ACC_HIB  = 2'b11
  } acc_e;

  function automatic logic acc_is_byte(acc_e a);
    return (a == ACC_LOB) || (a == ACC_HIB);
  endfunction
endpackage

// File: rtl/prf_wr_merge.sv
module prf_wr_merge #(
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 3,
  parameter int NUM_DATA = 4
) (
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] data,
  output logic              commit,
  output logic              bad,
  output logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] word
);
  import prf_pkg::*;
  localparam int HALF_W = DATA_W / 2;
  localparam int BYTE_W = DATA_W / 4;

  acc_e kind;
  assign kind = acc_e'(sel);

  always_comb begin
    mask = '0;
    word = '0;
    unique case (kind)
      ACC_WORD: begin
        mask = '1;
        word = data;
      end
      ACC_HALF: begin
        mask[HALF_W-1:0] = '1;
        word[HALF_W-1:0] = data[HALF_W-1:0];
      end
      ACC_LOB: begin
        mask[BYTE_W-1:0] = '1;
        word[BYTE_W-1:0] = data[BYTE_W-1:0];
      end
      default: begin
        mask[2*BYTE_W-1:BYTE_W] = '1;
        word[2*BYTE_W-1:BYTE_W] = data[BYTE_W-1:0];
      end
    endcase
  end

  assign bad    = acc_is_byte(kind) && ({1'b0, idx} >= (IDX_W+1)'(NUM_DATA));
  assign commit = wr_en && !bad;
endmodule

// File: rtl/prf_rd_extract.sv
module prf_rd_extract #(
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 3,
  parameter int NUM_DATA = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  idx,
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] word,
  output logic [DATA_W-1:0] data,
  output logic              bad
);
  import prf_pkg::*;
  localparam int HALF_W = DATA_W / 2;
  localparam int BYTE_W = DATA_W / 4;

  acc_e kind;
  assign kind = acc_e'(sel);
  assign bad  = acc_is_byte(kind) && ({1'b0, idx} >= (IDX_W+1)'(NUM_DATA));

  always_comb begin
    data = '0;
    if (!bad) begin
      unique case (kind)
        ACC_WORD: data = word;
        ACC_HALF: data[HALF_W-1:0] = word[HALF_W-1:0];
        ACC_LOB:  data[BYTE_W-1:0] = word[BYTE_W-1:0];
        default:  data[BYTE_W-1:0] = word[2*BYTE_W-1:BYTE_W];
      endcase
    end
  end

  AST_RD_ZERO_EXT: assert property (@(posedge clk) disable iff (rst)
    (sel != 2'b00) |-> (data[DATA_W-1:HALF_W] == '0)); // R5
  AST_BAD_RD_ZERO: assert property (@(posedge clk) disable iff (rst)
    bad |-> (data == '0)); // R7
endmodule

// File: rtl/prf_storage.sv
module prf_storage #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8,
  parameter int IDX_W    = 3,
  parameter int N_RD     = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         we,
  input  logic [IDX_W-1:0]             widx,
  input  logic [DATA_W-1:0]            wmask,
  input  logic [DATA_W-1:0]            wword,
  input  logic [N_RD-1:0][IDX_W-1:0]   rd_idx,
  output logic [N_RD-1:0][DATA_W-1:0]  rd_word
);
  logic [DATA_W-1:0] mem [NUM_REGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
    end else if (we) begin
      mem[widx] <= (mem[widx] & ~wmask) | (wword & wmask);
    end
  end

  for (genvar p = 0; p < N_RD; p++) begin : g_rd
    assign rd_word[p] = mem[rd_idx[p]];
  end

  AST_KEEP_UNSELECTED: assert property (@(posedge clk) disable iff (rst)
    we |=> ((mem[$past(widx)] & ~$past(wmask)) == ($past(mem[widx]) & ~$past(wmask)))); // R4
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    we |=> ((mem[$past(widx)] & $past(wmask)) == ($past(wword) & $past(wmask)))); // R2
endmodule

// File: rtl/prf_regfile.sv
module prf_regfile #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8,
  parameter int NUM_DATA = 4,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd0_idx,
  input  logic [1:0]        rd0_sel,
  output logic [DATA_W-1:0] rd0_data,
  input  logic [IDX_W-1:0]  rd1_idx,
  input  logic [1:0]        rd1_sel,
  output logic [DATA_W-1:0] rd1_data,
  output logic              acc_err
);
  localparam int N_RD = 2;

  logic              w_commit, w_bad;
  logic [DATA_W-1:0] w_mask, w_word;
  logic [N_RD-1:0][IDX_W-1:0]  r_idx;
  logic [N_RD-1:0][1:0]        r_sel;
  logic [N_RD-1:0][DATA_W-1:0] r_word, r_data;
  logic [N_RD-1:0]             r_bad;
  logic                        any_bad;
  logic                        err_q;

  assign r_idx[0] = rd0_idx;
  assign r_idx[1] = rd1_idx;
  assign r_sel[0] = rd0_sel;
  assign r_sel[1] = rd1_sel;

  prf_wr_merge #(.DATA_W(DATA_W), .IDX_W(IDX_W), .NUM_DATA(NUM_DATA)) u_merge (
    .wr_en(wr_en), .idx(wr_idx), .sel(wr_sel), .data(wr_data),
    .commit(w_commit), .bad(w_bad), .mask(w_mask), .word(w_word)
  );

  prf_storage #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .N_RD(N_RD)) u_store (
    .clk(clk), .rst(rst), .we(w_commit), .widx(wr_idx), .wmask(w_mask), .wword(w_word),
    .rd_idx(r_idx), .rd_word(r_word)
  );

  for (genvar p = 0; p < N_RD; p++) begin : g_port
    prf_rd_extract #(.DATA_W(DATA_W), .IDX_W(IDX_W), .NUM_DATA(NUM_DATA)) u_ext (
      .clk(clk), .rst(rst), .idx(r_idx[p]), .sel(r_sel[p]), .word(r_word[p]),
      .data(r_data[p]), .bad(r_bad[p])
    );
  end

  assign rd0_data = r_data[0];
  assign rd1_data = r_data[1];
  assign any_bad  = (wr_en && w_bad) || (|r_bad);

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= any_bad;
  end
  assign acc_err = err_q;

  AST_ERR_FOLLOWS_BAD: assert property (@(posedge clk) disable iff (rst)
    any_bad |=> acc_err); // R8
  AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    acc_err |-> $past(any_bad)); // R8
  AST_BAD_WRITE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && w_bad && rd0_idx == wr_idx && rd0_sel == 2'b00)
    |=> ((rd0_data == $past(rd0_data)) || (rd0_idx != $past(rd0_idx)) || (rd0_sel != $past(rd0_sel)))); // R6
endmodule

// File: tb/prf_regfile_tb_top.sv
module prf_regfile_tb_top;
  localparam int DW = 32;
  localparam int NR = 8;
  localparam int ND = 4;
  localparam int IW = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [IW-1:0] wr_idx = '0;
  logic [1:0]    wr_sel = '0;
  logic [DW-1:0] wr_data = '0;
  logic [IW-1:0] rd0_idx = '0;
  logic [1:0]    rd0_sel = '0;
  logic [DW-1:0] rd0_data;
  logic [IW-1:0] rd1_idx = '0;
  logic [1:0]    rd1_sel = '0;
  logic [DW-1:0] rd1_data;
  logic          acc_err;

  prf_regfile dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd0_idx(rd0_idx), .rd0_sel(rd0_sel), .rd0_data(rd0_data),
    .rd1_idx(rd1_idx), .rd1_sel(rd1_sel), .rd1_data(rd1_data), .acc_err(acc_err)
  );

  typedef struct {
    int            port;
    logic [DW-1:0] exp;
    string         tag;
  } item_t;

  item_t         sbq[$];
  int            n_cmp = 0;
  int            n_bad = 0;
  logic [DW-1:0] model [NR];
  logic          prev_bad = 1'b0;
  bit            done = 1'b0;

  function automatic logic bad_acc(int i, logic [1:0] s);
    return s[1] && (i >= ND);
  endfunction

  function automatic logic [DW-1:0] mread(int i, logic [1:0] s);
    if (bad_acc(i, s)) return '0;
    case (s)
      2'b00:   return model[i];
      2'b01:   return {16'h0, model[i][15:0]};
      2'b10:   return {24'h0, model[i][7:0]};
      default: return {24'h0, model[i][15:8]};
    endcase
  endfunction

  task automatic cyc(input logic r, input logic we, input int wi, input logic [1:0] ws,
                     input logic [DW-1:0] wd, input int a, input logic [1:0] as_,
                     input int b, input logic [1:0] bs, input string tag);
    logic wb;
    @(negedge clk);
    rst = r; wr_en = we; wr_idx = wi[IW-1:0]; wr_sel = ws; wr_data = wd;
    rd0_idx = a[IW-1:0]; rd0_sel = as_; rd1_idx = b[IW-1:0]; rd1_sel = bs;
    sbq.push_back('{0, mread(a, as_), tag});
    sbq.push_back('{1, mread(b, bs), tag});
    sbq.push_back('{2, {{(DW-1){1'b0}}, prev_bad}, "R8"});
    wb = bad_acc(wi, ws);
    if (r) begin
      for (int i = 0; i < NR; i++) model[i] = '0;
      prev_bad = 1'b0;
    end else begin
      prev_bad = (we && wb) || bad_acc(a, as_) || bad_acc(b, bs);
      if (we && !wb) begin
        case (ws)
          2'b00:   model[wi] = wd;
          2'b01:   model[wi][15:0] = wd[15:0];
          2'b10:   model[wi][7:0] = wd[7:0];
          default: model[wi][15:8] = wd[7:0];
        endcase
      end
    end
  endtask

  always @(negedge clk) begin : monitor
    item_t         it;
    logic [DW-1:0] act;
    #3;
    while (sbq.size() > 0) begin
      it = sbq.pop_front();
      case (it.port)
        0:       act = rd0_data;
        1:       act = rd1_data;
        default: act = {{(DW-1){1'b0}}, acc_err};
      endcase
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s port%0d actual=%h expected=%h", it.tag, it.port, act, it.exp);
      end
    end
  end

  function automatic logic [DW-1:0] fill(int i);
    return 32'hA0B0C0D0 ^ (i * 32'h01110111);
  endfunction

  initial begin
    for (int i = 0; i < NR; i++) model[i] = '0;
    // R1: reset, then all registers read zero
    cyc(1, 0, 0, 2'b00, '0, 0, 2'b00, 1, 2'b00, "R1");
    for (int i = 0; i < NR; i += 2) cyc(0, 0, 0, 2'b00, '0, i, 2'b00, i + 1, 2'b00, "R1");
    // R2 / R9: full writes; same-cycle reads see the old value
    for (int i = 0; i < NR; i++) cyc(0, 1, i, 2'b00, fill(i), i, 2'b00, (i + 7) % NR, 2'b00, "R9");
    for (int i = 0; i < NR; i++) cyc(0, 0, 0, 2'b00, '0, i, 2'b00, (i + 3) % NR, 2'b00, "R2");
    // R3: half writes keep the upper half
    cyc(0, 1, 1, 2'b01, 32'hFFFF1234, 1, 2'b00, 5, 2'b00, "R3");
    cyc(0, 1, 5, 2'b01, 32'hDEADBEEF, 1, 2'b00, 5, 2'b00, "R3");
    cyc(0, 0, 0, 2'b00, '0, 1, 2'b00, 5, 2'b00, "R3");
    // R4: byte writes on data registers
    cyc(0, 1, 0, 2'b10, 32'hFFFFFF5A, 0, 2'b00, 3, 2'b00, "R4");
    cyc(0, 1, 0, 2'b11, 32'h777777C3, 0, 2'b00, 3, 2'b00, "R4");
    cyc(0, 1, 3, 2'b11, 32'h00000011, 0, 2'b00, 3, 2'b00, "R4");
    cyc(0, 1, 3, 2'b10, 32'h00000022, 0, 2'b00, 3, 2'b00, "R4");
    cyc(0, 0, 0, 2'b00, '0, 0, 2'b00, 3, 2'b00, "R4");
    // R5: narrow reads zero-extended
    cyc(0, 0, 0, 2'b00, '0, 0, 2'b10, 0, 2'b11, "R5");
    cyc(0, 0, 0, 2'b00, '0, 2, 2'b01, 6, 2'b01, "R5");
    cyc(0, 0, 0, 2'b00, '0, 3, 2'b11, 1, 2'b10, "R5");
    // R6: byte writes to index/pointer registers dropped
    cyc(0, 1, 6, 2'b10, 32'h000000FF, 6, 2'b00, 4, 2'b00, "R6");
    cyc(0, 1, 4, 2'b11, 32'h000000EE, 6, 2'b00, 4, 2'b00, "R6");
    cyc(0, 0, 0, 2'b00, '0, 6, 2'b00, 4, 2'b00, "R6");
    cyc(0, 0, 0, 2'b00, '0, 6, 2'b00, 4, 2'b00, "R6");
    // R7: byte reads of index/pointer registers return zero
    cyc(0, 0, 0, 2'b00, '0, 4, 2'b10, 7, 2'b11, "R7");
    cyc(0, 0, 0, 2'b00, '0, 3, 2'b10, 5, 2'b11, "R7");
    cyc(0, 0, 0, 2'b00, '0, 0, 2'b00, 1, 2'b00, "R7");
    // R10: disabled write has no effect
    cyc(0, 0, 2, 2'b00, 32'h0, 2, 2'b00, 2, 2'b01, "R10");
    cyc(0, 0, 2, 2'b00, 32'h0, 2, 2'b00, 2, 2'b01, "R10");
    // R9: write seen by both ports on the next cycle
    cyc(0, 1, 7, 2'b00, 32'h12345678, 7, 2'b00, 7, 2'b01, "R9");
    cyc(0, 0, 0, 2'b00, '0, 7, 2'b00, 7, 2'b01, "R9");
    // R1: reset with a write and an illegal read presented
    cyc(1, 1, 2, 2'b00, 32'hFFFFFFFF, 5, 2'b10, 2, 2'b00, "R1");
    for (int i = 0; i < NR; i += 2) cyc(0, 0, 0, 2'b00, '0, i, 2'b00, i + 1, 2'b00, "R1");
    cyc(0, 0, 0, 2'b00, '0, 0, 2'b00, 0, 2'b00, "R8");
    @(negedge clk);
    #5;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog all-requirements actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule